// File: doc/BRIEF.md
# Reset Source Funnel Controller

This block merges every reset request of a small controller into one system reset and keeps a flag register that names the cause of the latest reset. A power-on event, which arrives here as an already-digital input, holds the system in reset. The external reset pad is pulled low for the same time. Release comes only after a configurable number of clock cycles. Every other source (external pin, missing clock, watchdog, comparator, real-time-clock alarm, software request, illegal flash access) produces a shorter reset. That reset has a fixed hold length and is stretched while requests keep arriving.

A one-bit supply-monitor disable can be written while the system runs. While the monitor is off, any reset request is promoted to a full power-on sequence, and that sequence turns the monitor back on. The flag register therefore always reads either the power-on flag alone or exactly one source flag.

Top module: `rst_funnel_ctrl`

## Requirements
- R1: While `por_evt` is sampled high, and in the cycle after it falls, `sys_rst` and `pin_drive_low` are 1, `rst_flags` reads 0x02 (bit 1 is the power-on flag, every other bit 0), and `mon_en` is 1.
- R2: After a power-on event, `sys_rst` falls at the (POR_CYCLES+1)-th rising edge after the last edge at which `por_evt` was high.
- R3: With the monitor enabled and the system running, a request on any source sets `sys_rst` at the next rising edge. `pin_drive_low` always equals `sys_rst`.
- R4: A reset from a source other than power-on clears the power-on flag and sets exactly one flag. The flag positions are pin = bit 0, missing clock = bit 2, watchdog = bit 3, comparator = bit 4, clock alarm = bit 5, software = bit 6, flash fault = bit 7.
- R5: When several sources request in the same cycle, the flag with the lowest bit number is recorded.
- R6: A source reset that starts at edge E releases `sys_rst` at edge E+HOLD_CYCLES+1.
- R7: A request during a source reset's hold or release phase restarts the hold count from its own edge. The recorded flag does not change.
- R8: Requests that arrive during the power-on delay are ignored: the flags stay 0x02 and the release edge does not move.
- R9: Once released, `rst_flags` holds its value until the next reset.
- R10: While running, a write (`pmu_wr`=1) with `pmu_mon_dis`=1 clears `mon_en`, and a write with `pmu_mon_dis`=0 sets it. Writes made while `sys_rst` is 1 have no effect.
- R11: With `mon_en`=0, any request starts a full power-on sequence: `rst_flags`=0x02, `mon_en` back to 1, and release at edge E+POR_CYCLES+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_evt | input | 1 | Power-on event, active high; also resets the block |
| pin_req | input | 1 | External reset pin request (already synchronised) |
| mclk_miss | input | 1 | Missing-clock detector request |
| wdt_expire | input | 1 | Watchdog timeout request |
| cmp_trip | input | 1 | Comparator reset request |
| rtc_alarm | input | 1 | Real-time-clock alarm reset request |
| sw_req | input | 1 | Software reset request |
| flash_fault | input | 1 | Illegal flash operation request |
| pmu_wr | input | 1 | Write strobe for the monitor-disable bit |
| pmu_mon_dis | input | 1 | Written value; 1 disables the supply monitor |
| sys_rst | output | 1 | System reset, active high, registered |
| pin_drive_low | output | 1 | Pull-down enable for the open-drain reset pad |
| rst_flags | output | 8 | Reset cause flags |
| mon_en | output | 1 | Supply monitor enabled |

## Verification
The bench builds the block with POR_CYCLES=20 and HOLD_CYCLES=4. With these values both release edges can be counted exactly, and the power-on window is long enough to inject a request in its middle and show that it is ignored. A hold of four cycles gives room to restart the count from inside the hold. It also gives room to attempt a monitor write during reset. With these sizes the monitor-off promotion to a full power-on sequence finishes in a few dozen cycles.

// File: rtl/rst_funnel_pkg.sv
package rst_funnel_pkg;
  localparam int FLAG_W  = 8;
  localparam int POR_BIT = 1;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_POR  = 2'd1,
    ST_HOLD = 2'd2,
    ST_REL  = 2'd3
  } seq_st_t;

  localparam logic [FLAG_W-1:0] POR_FLAGS = FLAG_W'(1) << POR_BIT;
endpackage

// File: rtl/rst_prio_pick.sv
module rst_prio_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] pick,
  output logic         any
);
  // lowest set bit wins
  always_comb begin
    pick = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_funnel_pkg::*;
#(
  parameter int POR_CYCLES  = 1024,
  parameter int HOLD_CYCLES = 8
) (
  input  logic    clk,
  input  logic    por_evt,
  input  logic    any_req,
  input  logic    mon_en,
  output seq_st_t state,
  output logic    sys_rst,
  output logic    pin_drive
);
  localparam int MAXC  = (POR_CYCLES > HOLD_CYCLES) ? POR_CYCLES : HOLD_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  seq_st_t          state_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      ST_RUN: begin
        if (any_req) begin
          state_n = mon_en ? ST_HOLD : ST_POR;
          cnt_n   = '0;
        end
      end
      ST_POR: begin
        if (cnt == POR_LAST) state_n = ST_REL;
        else                 cnt_n   = cnt + 1'b1;
      end
      ST_HOLD: begin
        if (any_req)              cnt_n   = '0;
        else if (cnt == HOLD_LAST) state_n = ST_REL;
        else                       cnt_n   = cnt + 1'b1;
      end
      ST_REL: begin
        if (any_req) begin
          state_n = ST_HOLD;
          cnt_n   = '0;
        end else begin
          state_n = ST_RUN;
        end
      end
      default: state_n = ST_POR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_evt) begin
      state     <= ST_POR;
      cnt       <= '0;
      sys_rst   <= 1'b1;
      pin_drive <= 1'b1;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      sys_rst   <= (state_n != ST_RUN);
      pin_drive <= (state_n != ST_RUN);
    end
  end
endmodule

// File: rtl/rst_flag_reg.sv
module rst_flag_reg
  import rst_funnel_pkg::*;
(
  input  logic              clk,
  input  logic              por_evt,
  input  seq_st_t           state,
  input  logic              any_req,
  input  logic [FLAG_W-1:0] pick,
  input  logic              pmu_wr,
  input  logic              pmu_mon_dis,
  output logic [FLAG_W-1:0] flags,
  output logic              mon_en
);
  logic running;
  assign running = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (por_evt) begin
      flags  <= POR_FLAGS;
      mon_en <= 1'b1;
    end else if (running && any_req) begin
      if (mon_en) begin
        flags <= pick;
      end else begin
        flags  <= POR_FLAGS;
        mon_en <= 1'b1;
      end
    end else if (running && pmu_wr) begin
      mon_en <= ~pmu_mon_dis;
    end
  end
endmodule

// File: rtl/rst_funnel_ctrl.sv
module rst_funnel_ctrl
  import rst_funnel_pkg::*;
#(
  parameter int POR_CYCLES  = 1024,
  parameter int HOLD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       por_evt,
  input  logic       pin_req,
  input  logic       mclk_miss,
  input  logic       wdt_expire,
  input  logic       cmp_trip,
  input  logic       rtc_alarm,
  input  logic       sw_req,
  input  logic       flash_fault,
  input  logic       pmu_wr,
  input  logic       pmu_mon_dis,
  output logic       sys_rst,
  output logic       pin_drive_low,
  output logic [7:0] rst_flags,
  output logic       mon_en
);
  logic [FLAG_W-1:0] req_pos, pick;
  logic              any_req;
  seq_st_t           state;

  // requests placed at their flag positions; the power-on slot stays empty
  assign req_pos = {flash_fault, sw_req, rtc_alarm, cmp_trip,
                    wdt_expire, mclk_miss, 1'b0, pin_req};

  rst_prio_pick #(.W(FLAG_W)) u_pick (
    .req  (req_pos),
    .pick (pick),
    .any  (any_req)
  );

  rst_seq_fsm #(.POR_CYCLES(POR_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk       (clk),
    .por_evt   (por_evt),
    .any_req   (any_req),
    .mon_en    (mon_en),
    .state     (state),
    .sys_rst   (sys_rst),
    .pin_drive (pin_drive_low)
  );

  rst_flag_reg u_flags (
    .clk         (clk),
    .por_evt     (por_evt),
    .state       (state),
    .any_req     (any_req),
    .pick        (pick),
    .pmu_wr      (pmu_wr),
    .pmu_mon_dis (pmu_mon_dis),
    .flags       (rst_flags),
    .mon_en      (mon_en)
  );
endmodule

// File: rtl/rst_funnel_chk.sv
module rst_funnel_chk (
  input logic       clk,
  input logic       por_evt,
  input logic       pin_req,
  input logic       mclk_miss,
  input logic       wdt_expire,
  input logic       cmp_trip,
  input logic       rtc_alarm,
  input logic       sw_req,
  input logic       flash_fault,
  input logic       sys_rst,
  input logic       pin_drive_low,
  input logic [7:0] rst_flags,
  input logic       mon_en
);
  logic [6:0] req;
  assign req = {flash_fault, sw_req, rtc_alarm, cmp_trip, wdt_expire, mclk_miss, pin_req};

  assert_por_entry_R1: assert property (@(posedge clk) disable iff (por_evt)
    $past(por_evt) |-> (sys_rst && rst_flags == 8'h02 && mon_en));

  assert_pin_mirror_R3: assert property (@(posedge clk) disable iff (por_evt)
    sys_rst == pin_drive_low);

  assert_one_flag_R4: assert property (@(posedge clk) disable iff (por_evt)
    $countones(rst_flags) == 1);

  assert_src_entry_R4: assert property (@(posedge clk) disable iff (por_evt)
    (!sys_rst && req != 7'd0 && mon_en) |=> (sys_rst && !rst_flags[1]));

  assert_release_R6: assert property (@(posedge clk) disable iff (por_evt)
    $fell(sys_rst) |-> ($past(req) == 7'd0));

  assert_flags_in_reset_R7: assert property (@(posedge clk) disable iff (por_evt)
    sys_rst |=> $stable(rst_flags));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (por_evt)
    (!sys_rst && req == 7'd0) |=> $stable(rst_flags));

  assert_mon_locked_R10: assert property (@(posedge clk) disable iff (por_evt)
    sys_rst |=> $stable(mon_en));

  assert_soft_por_R11: assert property (@(posedge clk) disable iff (por_evt)
    (!sys_rst && req != 7'd0 && !mon_en) |=> (sys_rst && rst_flags == 8'h02 && mon_en));
endmodule

bind rst_funnel_ctrl rst_funnel_chk u_chk (
  .clk           (clk),
  .por_evt       (por_evt),
  .pin_req       (pin_req),
  .mclk_miss     (mclk_miss),
  .wdt_expire    (wdt_expire),
  .cmp_trip      (cmp_trip),
  .rtc_alarm     (rtc_alarm),
  .sw_req        (sw_req),
  .flash_fault   (flash_fault),
  .sys_rst       (sys_rst),
  .pin_drive_low (pin_drive_low),
  .rst_flags     (rst_flags),
  .mon_en        (mon_en)
);

// File: tb/sim_rst_funnel_ctrl.sv
`timescale 1ns/1ps
module sim_rst_funnel_ctrl;
  localparam int P = 20;
  localparam int H = 4;

  logic clk = 1'b0;
  logic por_evt = 1'b1;
  logic [6:0] src = '0;
  logic pmu_wr = 1'b0, pmu_mon_dis = 1'b0;
  logic sys_rst, pin_drive_low, mon_en;
  logic [7:0] rst_flags;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  rst_funnel_ctrl #(.POR_CYCLES(P), .HOLD_CYCLES(H)) u0 (
    .clk(clk), .por_evt(por_evt),
    .pin_req(src[0]), .mclk_miss(src[1]), .wdt_expire(src[2]), .cmp_trip(src[3]),
    .rtc_alarm(src[4]), .sw_req(src[5]), .flash_fault(src[6]),
    .pmu_wr(pmu_wr), .pmu_mon_dis(pmu_mon_dis),
    .sys_rst(sys_rst), .pin_drive_low(pin_drive_low),
    .rst_flags(rst_flags), .mon_en(mon_en)
  );

  // source vector (bit0 pin .. bit6 flash) , expected flags
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {7'b0000001, 8'h01}, {7'b0000010, 8'h04}, {7'b0000100, 8'h08},
    {7'b0001000, 8'h10}, {7'b0010000, 8'h20}, {7'b0100000, 8'h40},
    {7'b1000000, 8'h80}, {7'b1000100, 8'h08}, {7'b0110010, 8'h04},
    {7'b1111111, 8'h01}
  };

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (sys_rst && n < 500) begin
      tick();
      n++;
    end
  endtask

  task automatic pulse(input logic [6:0] v);
    src = v;
    tick();
    src = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    int n;
    // R1: reset state on power-on
    @(negedge clk);
    tick();
    check(sys_rst && pin_drive_low, "R1 rst+pin", {sys_rst, pin_drive_low}, 3);
    check(rst_flags == 8'h02, "R1 flags", rst_flags, 8'h02);
    check(mon_en == 1'b1, "R1 mon_en", mon_en, 1);
    por_evt = 1'b0;
    count_release(n);
    check(n == P + 1, "R2 por release", n, P + 1);
    check(rst_flags == 8'h02, "R1 flags after release", rst_flags, 8'h02);

    // R3 R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][14:8]);
      check(sys_rst && pin_drive_low, "R3 assert", {sys_rst, pin_drive_low}, 3);
      check(rst_flags == VEC[i][7:0], "R4/R5 flag", rst_flags, VEC[i][7:0]);
      count_release(n);
      check(n == H + 1, "R6 hold release", n, H + 1);
      tick();
    end

    // R9: flags hold while running
    repeat (10) tick();
    check(rst_flags == 8'h01, "R9 hold", rst_flags, 8'h01);

    // R7: request during hold restarts count, flag kept
    pulse(7'b0000100);
    tick();
    tick();
    pulse(7'b0001000);
    check(rst_flags == 8'h08, "R7 flag kept", rst_flags, 8'h08);
    count_release(n);
    check(n == H + 1, "R7 restart", n, H + 1);

    // R8: request during power-on delay ignored
    por_evt = 1'b1;
    tick();
    por_evt = 1'b0;
    repeat (3) tick();
    pulse(7'b0000100);
    check(rst_flags == 8'h02, "R8 flags", rst_flags, 8'h02);
    count_release(n);
    check(n == P + 1 - 4, "R8 release", n, P + 1 - 4);

    // R10: write enable/disable
    pmu_wr = 1'b1; pmu_mon_dis = 1'b1;
    tick();
    pmu_wr = 1'b0;
    check(mon_en == 1'b0 && !sys_rst, "R10 disable", mon_en, 0);
    pmu_wr = 1'b1; pmu_mon_dis = 1'b0;
    tick();
    pmu_wr = 1'b0;
    check(mon_en == 1'b1, "R10 enable", mon_en, 1);
    pulse(7'b0000001);
    pmu_wr = 1'b1; pmu_mon_dis = 1'b1;
    tick();
    pmu_wr = 1'b0;
    count_release(n);
    check(mon_en == 1'b1, "R10 write in reset ignored", mon_en, 1);

    // R11: disabled monitor promotes to full power-on
    pmu_wr = 1'b1; pmu_mon_dis = 1'b1;
    tick();
    pmu_wr = 1'b0;
    check(mon_en == 1'b0, "R11 precondition", mon_en, 0);
    pulse(7'b0100000);
    check(sys_rst == 1'b1, "R11 assert", sys_rst, 1);
    check(rst_flags == 8'h02, "R11 flags", rst_flags, 8'h02);
    check(mon_en == 1'b1, "R11 mon_en", mon_en, 1);
    count_release(n);
    check(n == P + 1, "R11 release", n, P + 1);

    finish_run();
  end
endmodule